// File: doc/BRIEF.md
# Receiver Controller Boot Sequencer

This block is a host-side state machine that brings a receive-side delay-tracking controller from reset to locked tracking. It talks to the controller through a plain register port: a request held with address, write flag and write data until a one-cycle acknowledge arrives. A `start` pulse launches a fixed script. The script programs the sampling-window skew, then turns the controller off and back on in two steps. It waits a long settle interval, reads the lock status and then reads the resulting delay code.

The delay code is accepted when it lies inside a guard band given by two input limits. Two conditions send the script back to the disable step without rewriting the skew: a lock status other than the expected value, or a delay code outside the band. After a bounded number of such retries the next failure ends the sequence with `fail`. A one-cycle `done` pulse marks the end of every sequence. Its outcome flags and the retry count stay visible until the next start.

Top module: `rxc_boot_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bus_req`, `done`, `pass` and `fail` are 0 and `retry_cnt` is 0.
- R2: After `start`, the first four accesses are writes, in this order: address 0x13 data 0x72 (skew code 2), then address 0x10 data 0x00, then address 0x10 data 0x02, then address 0x10 data 0x03.
- R3: `bus_req` stays high, with `bus_we`, `bus_addr` and `bus_wdata` unchanged, until a cycle in which `bus_ack` is high. It is low in the cycle after that acknowledge.
- R4: After the acknowledge of the write of 0x03, the block makes no access for exactly SETTLE_CYCLES cycles. The read request that follows rises on the (SETTLE_CYCLES+2)-th rising edge after the acknowledge edge.
- R5: The first access after the settle wait is a read of address 0x21. If the read returns any value other than 0x05, the block increments `retry_cnt` and resumes at the write of 0x00 to address 0x10. The skew write is not repeated.
- R6: After a lock status of 0x05, the block reads the delay code at address 0x22. The code passes when `guard_lo` <= code <= `guard_hi`, and both limits count as inside the band.
- R7: A delay code outside the band increments `retry_cnt` and resumes at the write of 0x00 to address 0x10.
- R8: When a failure occurs while `retry_cnt` already equals MAX_RETRY (8), the block pulses `done` with `fail`=1 and `pass`=0, keeps `retry_cnt` at MAX_RETRY and issues no further request.
- R9: On a passing delay code, `done` is high for exactly one cycle with `pass`=1 and `fail`=0, and `retry_cnt` equals the number of retries taken. `pass`, `fail` and `retry_cnt` hold until the next accepted `start`, which clears them.
- R10: A `start` pulse while a sequence is running has no effect on the access order or on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence when idle |
| guard_lo | input | 8 | Lowest accepted delay code |
| guard_hi | input | 8 | Highest accepted delay code |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge of the pending access |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| pass | output | 1 | Sequence ended locked and inside the guard band |
| fail | output | 1 | Sequence ended after exhausting retries |
| retry_cnt | output | 4 | Number of retries taken in the current or last sequence |

## Verification
The bench sets delay codes exactly at `guard_lo` and at `guard_hi`, and one step outside each limit. An off-by-one compare would either retry on a boundary code or accept an outside code, and so change the access list. It also makes the lock read fail, which checks that a retry resumes at the disable write. A design that resumed at the skew write would show an extra write. The bench measures the gap from the last enable acknowledge to the lock read to the exact edge, so a short or long settle counter shows up. A run that never locks must stop after exactly eight retries and then stay silent on the bus. A stray `start` in mid-sequence must not restart the script.

// File: rtl/rxc_boot_pkg.sv
package rxc_boot_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SKEW,
    S_DIS,
    S_EN1,
    S_EN2,
    S_WAIT,
    S_RLOCK,
    S_RDEL
  } seq_state_t;
endpackage

// File: rtl/rxc_bus_master.sv
module rxc_bus_master #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          xfer_done,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_done <= 1'b0;
      rdata_q   <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (!bus_req && go) begin
        bus_req   <= 1'b1;
        bus_we    <= we_i;
        bus_addr  <= addr_i;
        bus_wdata <= wdata_i;
      end else if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        xfer_done <= 1'b1;
        rdata_q   <= bus_rdata;
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack) |=> !bus_req);

endmodule

// File: rtl/rxc_settle_timer.sv
module rxc_settle_timer #(
  parameter int CYCLES = 135000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(CYCLES - 1));

endmodule

// File: rtl/rxc_band_check.sv
module rxc_band_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] code,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         in_band
);

  assign in_band = (code >= lo) && (code <= hi);

endmodule

// File: rtl/rxc_boot_seq.sv
module rxc_boot_seq
  import rxc_boot_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYCLES = 135000,
  parameter int MAX_RETRY     = 8,
  parameter logic [ADDR_W-1:0] SKEW_ADDR  = 8'h13,
  parameter logic [DATA_W-1:0] SKEW_VAL   = 8'h72,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h10,
  parameter logic [DATA_W-1:0] CTRL_OFF   = 8'h00,
  parameter logic [DATA_W-1:0] CTRL_ARM   = 8'h02,
  parameter logic [DATA_W-1:0] CTRL_RUN   = 8'h03,
  parameter logic [ADDR_W-1:0] LOCK_ADDR  = 8'h21,
  parameter logic [DATA_W-1:0] LOCK_OK    = 8'h05,
  parameter logic [ADDR_W-1:0] DELAY_ADDR = 8'h22,
  localparam int RETRY_W = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DATA_W-1:0]  guard_lo,
  input  logic [DATA_W-1:0]  guard_hi,
  output logic               bus_req,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ack,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic [RETRY_W-1:0] retry_cnt
);

  seq_state_t        state;
  logic              issued;
  logic              go;
  logic              acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic              xdone;
  logic [DATA_W-1:0] rd_q;
  logic              expired;
  logic              in_band;
  logic              bad_result;
  logic              at_limit;

  // Access selected by the current step
  always_comb begin
    acc_we    = 1'b1;
    acc_addr  = CTRL_ADDR;
    acc_wdata = CTRL_OFF;
    case (state)
      S_SKEW:  begin acc_addr = SKEW_ADDR; acc_wdata = SKEW_VAL; end
      S_EN1:   acc_wdata = CTRL_ARM;
      S_EN2:   acc_wdata = CTRL_RUN;
      S_RLOCK: begin acc_we = 1'b0; acc_addr = LOCK_ADDR; acc_wdata = '0; end
      S_RDEL:  begin acc_we = 1'b0; acc_addr = DELAY_ADDR; acc_wdata = '0; end
      default: ;
    endcase
  end

  assign go = !issued && (state != S_IDLE) && (state != S_WAIT);

  rxc_bus_master #(.AW(ADDR_W), .DW(DATA_W)) u_master (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .we_i      (acc_we),
    .addr_i    (acc_addr),
    .wdata_i   (acc_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .xfer_done (xdone),
    .rdata_q   (rd_q)
  );

  rxc_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == S_WAIT),
    .expired (expired)
  );

  rxc_band_check #(.W(DATA_W)) u_band (
    .code    (rd_q),
    .lo      (guard_lo),
    .hi      (guard_hi),
    .in_band (in_band)
  );

  assign bad_result = xdone && (((state == S_RLOCK) && (rd_q != LOCK_OK)) ||
                                ((state == S_RDEL) && !in_band));
  assign at_limit   = (retry_cnt == RETRY_W'(MAX_RETRY));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      issued    <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      retry_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (go)    issued <= 1'b1;
      if (xdone) issued <= 1'b0;
      if (bad_result) begin
        if (at_limit) begin
          state <= S_IDLE;
          done  <= 1'b1;
          fail  <= 1'b1;
        end else begin
          retry_cnt <= retry_cnt + 1'b1;
          state     <= S_DIS;
        end
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state     <= S_SKEW;
            pass      <= 1'b0;
            fail      <= 1'b0;
            retry_cnt <= '0;
          end
          S_SKEW:  if (xdone) state <= S_DIS;
          S_DIS:   if (xdone) state <= S_EN1;
          S_EN1:   if (xdone) state <= S_EN2;
          S_EN2:   if (xdone) state <= S_WAIT;
          S_WAIT:  if (expired) state <= S_RLOCK;
          S_RLOCK: if (xdone) state <= S_RDEL;
          S_RDEL:  if (xdone) begin
            state <= S_IDLE;
            done  <= 1'b1;
            pass  <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R4
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT) |-> !bus_req);

  // R8
  retry_cap_chk: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= RETRY_W'(MAX_RETRY));

  // R8
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> (retry_cnt == RETRY_W'(MAX_RETRY)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !bus_req);

endmodule

// File: tb/test_rxc_boot_seq.sv
module test_rxc_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;
  localparam int MAXR       = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] guard_lo = 8'h90;
  logic [7:0] guard_hi = 8'hB0;
  logic       bus_req, bus_we;
  logic [7:0] bus_addr, bus_wdata;
  logic       bus_ack = 1'b0;
  logic [7:0] bus_rdata = 8'h00;
  logic       done, pass, fail;
  logic [3:0] retry_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxc_boot_seq #(.SETTLE_CYCLES(SETTLE), .MAX_RETRY(MAXR)) i_rxc_boot_seq (
    .clk(clk), .rst(rst), .start(start), .guard_lo(guard_lo), .guard_hi(guard_hi),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .pass(pass), .fail(fail),
    .retry_cnt(retry_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int lock_v[16];
  int del_v[16];
  int q_we[$];
  int q_addr[$];
  int q_data[$];
  int exp_pass;
  int exp_retry;
  int dis_seen;
  int en2_ack_cyc;
  int txn;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Reference model: the list of accesses a correct sequencer makes, and its outcome
  task automatic build_model();
    q_we.delete(); q_addr.delete(); q_data.delete();
    q_we.push_back(1); q_addr.push_back('h13); q_data.push_back('h72);
    for (int a = 0; a <= MAXR; a++) begin
      q_we.push_back(1); q_addr.push_back('h10); q_data.push_back('h00);
      q_we.push_back(1); q_addr.push_back('h10); q_data.push_back('h02);
      q_we.push_back(1); q_addr.push_back('h10); q_data.push_back('h03);
      q_we.push_back(0); q_addr.push_back('h21); q_data.push_back(0);
      if (lock_v[a] == 5) begin
        q_we.push_back(0); q_addr.push_back('h22); q_data.push_back(0);
        if (del_v[a] >= int'(guard_lo) && del_v[a] <= int'(guard_hi)) begin
          exp_pass = 1; exp_retry = a;
          return;
        end
      end
    end
    exp_pass = 0; exp_retry = MAXR;
  endtask

  // Per-clock monitor: handshake rules (R3)
  logic       req_p = 1'b0, we_p = 1'b0;
  logic [7:0] addr_p = 8'h00, wd_p = 8'h00;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst && req_p) begin
        if (!bus_ack)
          chk(bus_req && bus_we == we_p && bus_addr == addr_p && bus_wdata == wd_p,
              "R3", "request held until ack", {bus_req, bus_addr}, {1'b1, addr_p});
        else
          chk(!bus_req, "R3", "request low after ack", bus_req, 0);
      end
      req_p = bus_req; we_p = bus_we; addr_p = bus_addr; wd_p = bus_wdata;
    end
  end

  // Register slave with varying latency, comparing each access with the model
  initial begin
    bit pending = 1'b0;
    int wait_n = 0;
    forever begin
      @(negedge clk);
      #1;
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (!pending) begin
          pending = 1'b1;
          wait_n = txn % 3;
          if (!bus_we && bus_addr == 8'h21)
            chk(cyc - en2_ack_cyc == SETTLE + 3, "R4", "settle gap to lock read",
                cyc - en2_ack_cyc, SETTLE + 3);
        end
        if (wait_n == 0) begin
          pending = 1'b0;
          txn++;
          bus_ack = 1'b1;
          if (q_we.size() == 0) begin
            chk(1'b0, "R8", "access beyond end of script", bus_addr, 0);
          end else begin
            int ew, ea, ed;
            ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
            chk(int'(bus_we) == ew && int'(bus_addr) == ea && (ew == 0 || int'(bus_wdata) == ed),
                (ea == 'h21) ? "R5" : (ea == 'h22) ? "R6" : "R2",
                "access order", {bus_we, bus_addr, bus_wdata}, {ew[0], ea[7:0], ed[7:0]});
          end
          if (bus_we && bus_addr == 8'h10 && bus_wdata == 8'h00) begin
            chk(int'(retry_cnt) == dis_seen, "R7", "retry count at disable write",
                retry_cnt, dis_seen);
            dis_seen++;
          end
          if (bus_we && bus_addr == 8'h10 && bus_wdata == 8'h03) en2_ack_cyc = cyc;
          if (!bus_we && bus_addr == 8'h21) bus_rdata = 8'(lock_v[dis_seen - 1]);
          else if (!bus_we && bus_addr == 8'h22) bus_rdata = 8'(del_v[dis_seen - 1]);
          else bus_rdata = 8'h00;
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic set_case(input int lk, input int dl);
    for (int i = 0; i < 16; i++) begin lock_v[i] = lk; del_v[i] = dl; end
  endtask

  task automatic run_case(input string nm, input bit mid_start);
    build_model();
    dis_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!pass && !fail && retry_cnt == 0, "R9", {nm, " outcome cleared by start"},
        {pass, fail, retry_cnt}, 0);
    if (mid_start) begin
      repeat (25) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(q_we.size() == 0, "R9", {nm, " all accesses made before done"}, q_we.size(), 0);
    chk(int'(pass) == exp_pass && int'(fail) == 1 - exp_pass,
        exp_pass ? "R9" : "R8", {nm, " outcome"}, {pass, fail}, {exp_pass[0], ~exp_pass[0]});
    chk(int'(retry_cnt) == exp_retry, exp_pass ? "R9" : "R8", {nm, " retries"}, retry_cnt, exp_retry);
    @(negedge clk);
    chk(!done, "R9", {nm, " done is one cycle"}, done, 0);
    repeat (10) begin
      @(negedge clk);
      chk(!bus_req, "R8", {nm, " bus quiet after done"}, bus_req, 0);
    end
    chk(int'(pass) == exp_pass && int'(retry_cnt) == exp_retry, "R9", {nm, " outcome held"},
        {pass, retry_cnt}, {exp_pass[0], exp_retry[3:0]});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=%0d cycles expected=done", WATCHDOG);
    finish_run();
  end

  initial begin
    txn = 0; en2_ack_cyc = 0; dis_seen = 0;
    repeat (4) @(negedge clk);
    // R1
    chk(!bus_req && !done && !pass && !fail && retry_cnt == 0, "R1", "state in reset",
        {bus_req, done, pass, fail, retry_cnt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !done && !pass && !fail && retry_cnt == 0, "R1", "state after reset",
        {bus_req, done, pass, fail, retry_cnt}, 0);

    // R2 R4 R6 R9: clean first attempt
    set_case(5, 'hA7);
    run_case("first-try", 1'b0);

    // R5: bad lock status once
    set_case(5, 'hA7); lock_v[0] = 4;
    run_case("lock-retry", 1'b0);

    // R7: code above band, then exactly at the upper limit (R6)
    set_case(5, 'hB0); del_v[0] = 'hB1;
    run_case("above-then-hi", 1'b0);

    // R10: code below band, then exactly at the lower limit, stray start mid-run
    set_case(5, 'h90); del_v[0] = 'h8F;
    run_case("below-then-lo-start", 1'b1);

    // R8: never inside band
    set_case(5, 'h20);
    run_case("band-exhaust", 1'b0);

    // R5 R8: never locks
    set_case(7, 'hA7);
    run_case("lock-exhaust", 1'b0);

    finish_run();
  end
endmodule